// File: doc/BRIEF.md
# Loss-Balancing Zero-State Sequencer for a Three-Level Active-Clamped Leg

This block builds, for one phase leg of a three-level converter with active clamping switches, the ordered list of leg states to apply during one half of a modulation sample period. The other half is the mirror image of this list, and that mirroring is done outside the block. Upstream logic provides the sector, the region, a symbolic transition pattern for the phase, the dwell times, the load current sign and the modulation index. The block then selects a primary and a secondary zero state for each zero-dwell interval, divides the zero dwell between them according to a ratio derived from the modulation index, and returns the segments one at a time over a valid/ready handshake.

The leg has four distinct zero states: upper-clamped with the outer switch on or off, and lower-clamped with the outer switch on or off. Choosing among them by voltage and current quadrant, and weighting that choice by modulation index, moves conduction loss off the inner switches when the index is high. The ratio is a two-piece linear function. Its slopes, offsets and breakpoint are set by parameters, and the result is clamped to the range from zero to one.

Top module: `zsq_sequencer`

## Requirements
- R1: After reset, `o_idle` is 1 and `o_seg_valid` is 0.
- R2: The state codes are 1 for the positive level, 6 for the negative level, and 2..5 for the zero states. The pattern codes are 0 = zeros then positive, 1 = negative then zeros, 2 = negative then zeros then positive, and 3 = zeros only. Segments always come out in this time order: negative level (duration `i_t_neg`), the zero group next to the negative level, the zero group next to the positive level, and the positive level (duration `i_t_pos`).
- R3: The zero group next to the positive level uses primary 3 and secondary 5 when `i_cur_pos`=0, and primary 5 and secondary 3 when `i_cur_pos`=1. The zero group next to the negative level uses primary 2 and secondary 4 when `i_cur_pos`=0, and primary 4 and secondary 2 when `i_cur_pos`=1. Pattern 3 uses the pair for the positive-level side.
- R4: The ratio k is in units of 1/256. It is `OFF_LO + floor(SLOPE_LO*m/256)` when m < `K_BREAK`, and `OFF_HI + floor(SLOPE_HI*m/256)` otherwise. The result is clamped to 0..256.
- R5: The primary duration of a group is `floor(d*k/256)` and the secondary duration is `d` minus the primary. For pattern 2, the negative-side group gets `d = floor(T0/2)` and the positive-side group gets the remainder. For the other patterns, the single group gets all of T0.
- R6: In region 1, each group spends its whole dwell in the primary state and no secondary segment appears.
- R7: In region 2 with an even sector, each zero group emits its secondary state before its primary state. In every other case the primary comes first.
- R8: A slot with zero duration is skipped, so `o_seg_dur` is never 0 while `o_seg_valid` is 1.
- R9: While `o_seg_valid`=1 and `i_seg_ready`=0, the state, duration and last flag stay unchanged.
- R10: `o_seg_last` marks the final segment. `o_idle` returns to 1 in the cycle after that segment is accepted. A request whose slots are all zero emits nothing.
- R11: `i_go` has no effect while the block is busy. The list in flight is emitted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_go | input | 1 | Load a new request; taken only when idle |
| i_sector | input | 3 | Sector number 1..6 |
| i_region | input | 3 | Region number 1..4 |
| i_pattern | input | 2 | Transition pattern code |
| i_cur_pos | input | 1 | Phase current sign, 1 = positive |
| i_t_pos | input | DW | Positive-level dwell |
| i_t_neg | input | DW | Negative-level dwell |
| i_t_zero | input | DW | Total zero-state dwell T0 |
| i_mod | input | MW | Modulation index, 0.8 fixed point |
| o_idle | output | 1 | No list in flight |
| o_seg_valid | output | 1 | Segment available |
| i_seg_ready | input | 1 | Consumer accepts segment |
| o_seg_state | output | 3 | Leg state code |
| o_seg_dur | output | DW | Segment duration |
| o_seg_last | output | 1 | Final segment of the half period |

## Verification
The bench builds the block with a 12-bit dwell width and a low-index segment with a negative offset and a slope of 2.0. With these values, an index of 0 drives k below zero, so the clamp to 0 is exercised and every primary zero state is dropped. The high segment uses the default slope of 1.75, which takes k past 256 at the top of the index range, so the secondary state disappears there. An index one step on either side of the breakpoint checks the piece selection. Odd zero dwells make both the half split and the truncated product round.

// File: rtl/zsq_pkg.sv
package zsq_pkg;
    typedef enum logic [1:0] {
        PAT_ZERO_POS     = 2'd0,
        PAT_NEG_ZERO     = 2'd1,
        PAT_NEG_ZERO_POS = 2'd2,
        PAT_ZERO_ONLY    = 2'd3
    } pat_e;

    localparam logic [2:0] ST_POS = 3'd1;
    localparam logic [2:0] ST_ZU2 = 3'd2;
    localparam logic [2:0] ST_ZU1 = 3'd3;
    localparam logic [2:0] ST_ZL1 = 3'd4;
    localparam logic [2:0] ST_ZL2 = 3'd5;
    localparam logic [2:0] ST_NEG = 3'd6;

    localparam int NGRP  = 2;
    localparam int NSLOT = 2 + 2 * NGRP;
endpackage

// File: rtl/zsq_ratio.sv
module zsq_ratio #(
    parameter int MW       = 8,
    parameter int KW       = MW + 1,
    parameter int BREAK    = 102,
    parameter int SLOPE_LO = 0,
    parameter int OFF_LO   = 128,
    parameter int SLOPE_HI = 448,
    parameter int OFF_HI   = -50
) (
    input  logic [MW-1:0] i_m,
    output logic [KW-1:0] o_k
);
    localparam int KMAX = 1 << MW;

    int prod_v;
    int raw_v;

    always_comb begin
        if (int'(i_m) < BREAK) begin
            prod_v = SLOPE_LO * int'(i_m);
            raw_v  = OFF_LO + (prod_v >>> MW);
        end else begin
            prod_v = SLOPE_HI * int'(i_m);
            raw_v  = OFF_HI + (prod_v >>> MW);
        end
        if (raw_v < 0) begin
            o_k = '0;
        end else if (raw_v > KMAX) begin
            o_k = KW'(KMAX);
        end else begin
            o_k = KW'(raw_v);
        end
    end
endmodule

// File: rtl/zsq_split.sv
module zsq_split #(
    parameter int DW = 16,
    parameter int MW = 8,
    parameter int KW = MW + 1
) (
    input  logic [DW-1:0] i_dwell,
    input  logic [KW-1:0] i_k,
    input  logic          i_prim_only,
    output logic [DW-1:0] o_prim,
    output logic [DW-1:0] o_sec
);
    localparam int PW = DW + KW;

    logic [PW-1:0] prod;
    logic [DW-1:0] scaled;

    assign prod   = PW'(i_dwell) * PW'(i_k);
    assign scaled = DW'(prod >> MW);
    assign o_prim = i_prim_only ? i_dwell : scaled;
    assign o_sec  = i_dwell - o_prim;
endmodule

// File: rtl/zsq_pair.sv
module zsq_pair
    import zsq_pkg::*;
(
    input  logic       i_pos_side,
    input  logic       i_cur_pos,
    output logic [2:0] o_prim,
    output logic [2:0] o_sec
);
    always_comb begin
        case ({i_pos_side, i_cur_pos})
            2'b11:   begin o_prim = ST_ZL2; o_sec = ST_ZU1; end
            2'b10:   begin o_prim = ST_ZU1; o_sec = ST_ZL2; end
            2'b01:   begin o_prim = ST_ZL1; o_sec = ST_ZU2; end
            default: begin o_prim = ST_ZU2; o_sec = ST_ZL1; end
        endcase
    end
endmodule

// File: rtl/zsq_sequencer.sv
module zsq_sequencer
    import zsq_pkg::*;
#(
    parameter int DW         = 16,
    parameter int MW         = 8,
    parameter int K_BREAK    = 102,
    parameter int K_SLOPE_LO = 0,
    parameter int K_OFF_LO   = 128,
    parameter int K_SLOPE_HI = 448,
    parameter int K_OFF_HI   = -50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_go,
    input  logic [2:0]    i_sector,
    input  logic [2:0]    i_region,
    input  logic [1:0]    i_pattern,
    input  logic          i_cur_pos,
    input  logic [DW-1:0] i_t_pos,
    input  logic [DW-1:0] i_t_neg,
    input  logic [DW-1:0] i_t_zero,
    input  logic [MW-1:0] i_mod,
    output logic          o_idle,
    output logic          o_seg_valid,
    input  logic          i_seg_ready,
    output logic [2:0]    o_seg_state,
    output logic [DW-1:0] o_seg_dur,
    output logic          o_seg_last
);
    localparam int KW = MW + 1;

    typedef struct packed {
        logic [NSLOT-1:0]         mask;
        logic [NSLOT-1:0][2:0]    st;
        logic [NSLOT-1:0][DW-1:0] du;
    } seq_t;

    seq_t s_d, s_q;

    pat_e          pat;
    logic [KW-1:0] k_val;
    logic          prim_only;
    logic          swap_ord;
    logic          use_neg;
    logic          use_pos;
    logic          sec_even;
    logic [DW-1:0] half_zero;
    logic [DW-1:0] grp_dw   [NGRP];
    logic [DW-1:0] grp_prim [NGRP];
    logic [DW-1:0] grp_sec  [NGRP];
    logic [2:0]    code_prim[NGRP];
    logic [2:0]    code_sec [NGRP];

    logic [NSLOT-1:0]         ld_mask;
    logic [NSLOT-1:0][2:0]    ld_st;
    logic [NSLOT-1:0][DW-1:0] ld_du;
    logic [NSLOT-1:0]         pick;

    assign pat       = pat_e'(i_pattern);
    assign prim_only = (i_region == 3'd1);
    assign sec_even  = (i_sector == 3'd2) || (i_sector == 3'd4) || (i_sector == 3'd6);
    assign swap_ord  = (i_region == 3'd2) && sec_even;
    assign use_neg   = (pat == PAT_NEG_ZERO) || (pat == PAT_NEG_ZERO_POS);
    assign use_pos   = (pat == PAT_ZERO_POS) || (pat == PAT_NEG_ZERO_POS);
    assign half_zero = i_t_zero >> 1;

    zsq_ratio #(
        .MW(MW), .KW(KW), .BREAK(K_BREAK),
        .SLOPE_LO(K_SLOPE_LO), .OFF_LO(K_OFF_LO),
        .SLOPE_HI(K_SLOPE_HI), .OFF_HI(K_OFF_HI)
    ) u_ratio (
        .i_m (i_mod),
        .o_k (k_val)
    );

    // group 0 sits next to the negative level, group 1 next to the positive level
    always_comb begin
        case (pat)
            PAT_NEG_ZERO:     begin grp_dw[0] = i_t_zero;  grp_dw[1] = '0; end
            PAT_NEG_ZERO_POS: begin grp_dw[0] = half_zero; grp_dw[1] = i_t_zero - half_zero; end
            default:          begin grp_dw[0] = '0;        grp_dw[1] = i_t_zero; end
        endcase
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        zsq_pair u_pair (
            .i_pos_side (g == 1),
            .i_cur_pos  (i_cur_pos),
            .o_prim     (code_prim[g]),
            .o_sec      (code_sec[g])
        );
        zsq_split #(.DW(DW), .MW(MW), .KW(KW)) u_split (
            .i_dwell     (grp_dw[g]),
            .i_k         (k_val),
            .i_prim_only (prim_only),
            .o_prim      (grp_prim[g]),
            .o_sec       (grp_sec[g])
        );
    end

    // slot layout in time order: neg level, two zero groups, pos level
    always_comb begin
        ld_st[0] = ST_NEG;
        ld_du[0] = use_neg ? i_t_neg : '0;
        for (int g = 0; g < NGRP; g++) begin
            if (swap_ord) begin
                ld_st[1 + 2*g] = code_sec[g];
                ld_du[1 + 2*g] = grp_sec[g];
                ld_st[2 + 2*g] = code_prim[g];
                ld_du[2 + 2*g] = grp_prim[g];
            end else begin
                ld_st[1 + 2*g] = code_prim[g];
                ld_du[1 + 2*g] = grp_prim[g];
                ld_st[2 + 2*g] = code_sec[g];
                ld_du[2 + 2*g] = grp_sec[g];
            end
        end
        ld_st[NSLOT-1] = ST_POS;
        ld_du[NSLOT-1] = use_pos ? i_t_pos : '0;
        for (int i = 0; i < NSLOT; i++) begin
            ld_mask[i] = (ld_du[i] != '0);
        end
    end

    assign o_idle      = (s_q.mask == '0);
    assign o_seg_valid = !o_idle;
    assign pick        = s_q.mask & (~s_q.mask + NSLOT'(1));
    assign o_seg_last  = o_seg_valid && ((s_q.mask & (s_q.mask - NSLOT'(1))) == '0);

    always_comb begin
        o_seg_state = '0;
        o_seg_dur   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (pick[i]) begin
                o_seg_state = o_seg_state | s_q.st[i];
                o_seg_dur   = o_seg_dur | s_q.du[i];
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (o_idle && i_go) begin
            s_d.mask = ld_mask;
            s_d.st   = ld_st;
            s_d.du   = ld_du;
        end else if (o_seg_valid && i_seg_ready) begin
            s_d.mask = s_q.mask & (s_q.mask - NSLOT'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/zsq_checker.sv
module zsq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          i_go,
    input logic [DW-1:0] i_t_zero,
    input logic          o_idle,
    input logic          o_seg_valid,
    input logic          i_seg_ready,
    input logic [2:0]    o_seg_state,
    input logic [DW-1:0] o_seg_dur,
    input logic          o_seg_last
);
    p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        o_seg_valid |-> (o_seg_state >= 3'd1) && (o_seg_state <= 3'd6));

    p_no_empty_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_seg_valid |-> (o_seg_dur != '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (o_seg_valid && !i_seg_ready) |=>
            (o_seg_valid && $stable(o_seg_state) && $stable(o_seg_dur) && $stable(o_seg_last)));

    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_seg_valid && i_seg_ready && o_seg_last) |=> o_idle);

    p_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (o_idle && i_go && (i_t_zero != '0)) |=> o_seg_valid);
endmodule

bind zsq_sequencer zsq_checker #(.DW(DW)) u_zsq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .i_go        (i_go),
    .i_t_zero    (i_t_zero),
    .o_idle      (o_idle),
    .o_seg_valid (o_seg_valid),
    .i_seg_ready (i_seg_ready),
    .o_seg_state (o_seg_state),
    .o_seg_dur   (o_seg_dur),
    .o_seg_last  (o_seg_last)
);

// File: tb/zsq_sequencer_bench.sv
`timescale 1ns/1ps
module zsq_sequencer_bench;
    localparam int DW    = 12;
    localparam int MW    = 8;
    localparam int BRK   = 102;
    localparam int SL_LO = 512;
    localparam int OF_LO = -20;
    localparam int SL_HI = 448;
    localparam int OF_HI = -50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          i_go = 1'b0;
    logic [2:0]    i_sector = 3'd1;
    logic [2:0]    i_region = 3'd3;
    logic [1:0]    i_pattern = 2'd0;
    logic          i_cur_pos = 1'b0;
    logic [DW-1:0] i_t_pos = '0;
    logic [DW-1:0] i_t_neg = '0;
    logic [DW-1:0] i_t_zero = '0;
    logic [MW-1:0] i_mod = '0;
    logic          o_idle;
    logic          o_seg_valid;
    logic          i_seg_ready = 1'b0;
    logic [2:0]    o_seg_state;
    logic [DW-1:0] o_seg_dur;
    logic          o_seg_last;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_st[6];
    int exp_du[6];
    int exp_n;

    zsq_sequencer #(
        .DW(DW), .MW(MW), .K_BREAK(BRK),
        .K_SLOPE_LO(SL_LO), .K_OFF_LO(OF_LO),
        .K_SLOPE_HI(SL_HI), .K_OFF_HI(OF_HI)
    ) u_zsq_sequencer (
        .clk(clk), .rst_n(rst_n), .i_go(i_go), .i_sector(i_sector),
        .i_region(i_region), .i_pattern(i_pattern), .i_cur_pos(i_cur_pos),
        .i_t_pos(i_t_pos), .i_t_neg(i_t_neg), .i_t_zero(i_t_zero), .i_mod(i_mod),
        .o_idle(o_idle), .o_seg_valid(o_seg_valid), .i_seg_ready(i_seg_ready),
        .o_seg_state(o_seg_state), .o_seg_dur(o_seg_dur), .o_seg_last(o_seg_last)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // R4 ratio model
    function automatic int k_of(input int m);
        int v;
        if (m < BRK) v = OF_LO + ((SL_LO * m) >>> MW);
        else         v = OF_HI + ((SL_HI * m) >>> MW);
        if (v < 0) v = 0;
        if (v > 256) v = 256;
        return v;
    endfunction

    function automatic void add_slot(input int st, input int du);
        if (du != 0) begin
            exp_st[exp_n] = st;
            exp_du[exp_n] = du;
            exp_n = exp_n + 1;
        end
    endfunction

    function automatic void model(input int sec, input int rg, input int pt, input int cur,
                                  input int tp, input int tn, input int tz, input int m);
        int kk, half, dw, pr, sc, cp, cs;
        bit sw;
        exp_n = 0;
        kk = k_of(m);
        half = tz / 2;
        sw = (rg == 2) && (sec % 2 == 0);
        add_slot(6, (pt == 1 || pt == 2) ? tn : 0);
        for (int g = 0; g < 2; g++) begin
            if (g == 0) dw = (pt == 1) ? tz : (pt == 2) ? half : 0;
            else        dw = (pt == 1) ? 0 : (pt == 2) ? tz - half : tz;
            pr = (rg == 1) ? dw : ((dw * kk) >> MW);
            sc = dw - pr;
            if (g == 1) begin cp = cur ? 5 : 3; cs = cur ? 3 : 5; end
            else        begin cp = cur ? 4 : 2; cs = cur ? 2 : 4; end
            if (sw) begin add_slot(cs, sc); add_slot(cp, pr); end
            else    begin add_slot(cp, pr); add_slot(cs, sc); end
        end
        add_slot(1, (pt == 0 || pt == 2) ? tp : 0);
    endfunction

    task automatic chk(input string tag, input bit ok, input int act, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run(input string tag, input int sec, input int rg, input int pt, input int cur,
                       input int tp, input int tn, input int tz, input int m, input bit poke);
        int n, guard;
        bit seen, rdy;
        model(sec, rg, pt, cur, tp, tn, tz, m);
        @(negedge clk);
        i_sector = 3'(sec); i_region = 3'(rg); i_pattern = 2'(pt); i_cur_pos = cur[0];
        i_t_pos = DW'(tp); i_t_neg = DW'(tn); i_t_zero = DW'(tz); i_mod = MW'(m);
        i_go = 1'b1; i_seg_ready = 1'b0;
        @(negedge clk);
        i_go = 1'b0;
        n = 0; guard = 0; seen = 1'b0;
        while (n < exp_n && guard < 400) begin
            if (poke && guard == 1) begin
                i_go = 1'b1; i_pattern = 2'd3; i_t_zero = DW'(7); i_region = 3'd1; i_mod = '0;
            end else begin
                i_go = 1'b0;
            end
            if (!o_seg_valid) begin
                chk(tag, 1'b0, 0, 1);
                i_seg_ready = 1'b0;
            end else begin
                chk(seen ? "R9 hold" : tag,
                    (int'(o_seg_state) == exp_st[n]) && (int'(o_seg_dur) == exp_du[n]) &&
                    (o_seg_last == (n == exp_n - 1)),
                    int'(o_seg_state) * 10000 + int'(o_seg_dur),
                    exp_st[n] * 10000 + exp_du[n]);
                rdy = ($urandom % 3) != 0;
                i_seg_ready = rdy;
                seen = !rdy;
                if (rdy) n = n + 1;
            end
            @(negedge clk);
            guard = guard + 1;
        end
        i_go = 1'b0;
        i_seg_ready = 1'b0;
        chk("R10 idle after list", o_idle && !o_seg_valid, int'(o_idle), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", o_idle && !o_seg_valid, int'(o_seg_valid), 0);

        run("R2 crossing order",          1, 3, 2, 1, 100, 80, 400, 200, 1'b0);
        run("R3 pos side neg current",    1, 3, 0, 0, 90, 0, 300, 150, 1'b0);
        run("R3 pos side pos current",    3, 4, 0, 1, 90, 0, 300, 150, 1'b0);
        run("R3 neg side pos current",    5, 3, 1, 1, 0, 70, 333, 130, 1'b0);
        run("R3 neg side neg current",    1, 4, 1, 0, 0, 70, 333, 130, 1'b0);
        run("R4 below breakpoint",        1, 3, 0, 1, 10, 0, 1000, 101, 1'b0);
        run("R4 at breakpoint",           1, 3, 0, 1, 10, 0, 1000, 102, 1'b0);
        run("R4 clamp low R8 skip",       1, 3, 1, 0, 0, 30, 500, 0, 1'b0);
        run("R4 clamp high R8 skip",      1, 3, 0, 0, 30, 0, 500, 255, 1'b0);
        run("R5 odd dwell split",         1, 3, 2, 0, 55, 66, 1001, 150, 1'b0);
        run("R6 region one primary only", 1, 1, 3, 1, 0, 0, 800, 180, 1'b0);
        run("R6 region one crossing",     2, 1, 2, 0, 40, 50, 801, 180, 1'b0);
        run("R7 region two even sector",  2, 2, 2, 1, 100, 80, 600, 170, 1'b0);
        run("R7 region two odd sector",   1, 2, 2, 1, 100, 80, 600, 170, 1'b0);
        run("R8 dwell of one",            3, 3, 2, 1, 0, 0, 1, 200, 1'b0);
        run("R11 go while busy",          1, 3, 2, 0, 100, 80, 400, 120, 1'b1);

        // R10 empty request: nothing is emitted
        run("R10 empty request", 1, 3, 3, 0, 50, 50, 0, 100, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk("R10 empty stays idle", o_idle && !o_seg_valid, int'(o_seg_valid), 0);
        end

        for (int it = 0; it < 80; it++) begin
            run("R3 random mix", 1 + int'($urandom % 6), 1 + int'($urandom % 4),
                int'($urandom % 4), int'($urandom % 2),
                int'($urandom % 4096), int'($urandom % 4096), int'($urandom % 4096),
                int'($urandom % 256), ($urandom % 8) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule